// File: doc/BRIEF.md
# Linear-Pipeline Trie Longest-Prefix Lookup

This block resolves the longest matching route prefix for a destination address by walking a binary trie spread over a single linear chain of pipeline stages. Each stage owns a small node memory. A new lookup may enter every clock cycle. It carries its address, a pointer to the next trie node to visit, the number of address bits consumed so far, and the best next hop found so far. A stage visits a node only when the lookup's pointer names that stage. Otherwise the lookup passes through untouched. Because of this, trie nodes can sit in any later stage, not only in the stage that matches their depth, and the node count can be balanced across stage memories.

Route updates enter through a write port. Each write travels down the chain in the same slot as the lookup presented with it, and it writes its target stage's memory when it reaches that stage. Lookups therefore see a table state that is consistent with their order of entry. Every result emerges a fixed number of cycles after its lookup, in entry order.

Top module: `lpm_trie_pipe`

## Requirements
- R1: A lookup may be presented on every cycle. `res_valid_o` rises exactly NUM_STAGES cycles after `lkp_valid_i` was sampled high, and results leave in the order the lookups entered, including when idle cycles separate lookups.
- R2: Address bits are consumed most significant first, one per visited node: bit value 0 follows the left child and 1 follows the right child. The result is the next hop of the deepest visited node that holds a prefix, or 0 when no visited node holds one.
- R3: A stage visits a node only when the lookup's pointer stage tag equals the stage index (0 to NUM_STAGES-1). Otherwise it forwards pointer, depth and best hop unchanged, so a child may sit in any later stage.
- R4: A node pointer is {stage tag, node index} with the tag in the upper TAG_W bits. Tag value NUM_STAGES is the null pointer, which ends the walk. Every lookup starts at stage 0, index 0.
- R5: An update presented with `upd_valid_i` writes node `upd_index_i` of stage `upd_stage_i` as it passes that stage, travelling in the slot of the same cycle. Lookups entered in that cycle or earlier see the old node, and later lookups see the new one. Lookups are never stalled or dropped.
- R6: After reset, `res_valid_o` is low and every node has null children and no prefix, so every lookup returns next hop 0.
- R7: `res_hop_o` is 0 whenever `res_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup present this cycle |
| lkp_addr_i | input | ADDR_W | Destination address to resolve |
| upd_valid_i | input | 1 | Node write present this cycle |
| upd_stage_i | input | TAG_W | Stage whose memory is written |
| upd_index_i | input | IDX_W | Node index within that stage |
| upd_left_i | input | TAG_W+IDX_W | Left child pointer {tag, index} |
| upd_right_i | input | TAG_W+IDX_W | Right child pointer {tag, index} |
| upd_has_hop_i | input | 1 | Node holds a prefix |
| upd_hop_i | input | HOP_W | Next hop of that prefix |
| res_valid_o | output | 1 | Result present |
| res_hop_o | output | HOP_W | Longest-match next hop |

## Verification
Every result is due exactly NUM_STAGES rising edges after its lookup is sampled. The bench drives and samples on falling edges, stores the expected valid and hop for each cycle in a ring, and compares the output sampled NUM_STAGES cycles later against that entry. A lookup is scored against the reference table as it stood when the lookup was driven, before any update in the same slot is applied. That is exactly how R5 orders a write against the lookups around it. The address space is swept exhaustively under two node placements, one with a node in every stage and one that leaves nop stages, and also after reset with empty memories.

// File: rtl/lpm_trie_pkg.sv
package lpm_trie_pkg;
  localparam int unsigned DEF_STAGES = 6;
  localparam int unsigned DEF_ADDR_W = 8;
  localparam int unsigned DEF_IDX_W  = 4;
  localparam int unsigned DEF_HOP_W  = 4;

  typedef enum logic {
    BR_LEFT  = 1'b0,
    BR_RIGHT = 1'b1
  } branch_e;
endpackage

// File: rtl/trie_node_mem.sv
module trie_node_mem #(
  parameter int unsigned IDX_W = 4,
  parameter int unsigned PTR_W = 7,
  parameter int unsigned HOP_W = 4,
  parameter logic [PTR_W-1:0] NULL_PTR = '0,
  localparam int unsigned ENTRIES = 1 << IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] widx_i,
  input  logic [PTR_W-1:0] wleft_i,
  input  logic [PTR_W-1:0] wright_i,
  input  logic             whas_i,
  input  logic [HOP_W-1:0] whop_i,
  input  logic [IDX_W-1:0] ridx_i,
  output logic [PTR_W-1:0] rleft_o,
  output logic [PTR_W-1:0] rright_o,
  output logic             rhas_o,
  output logic [HOP_W-1:0] rhop_o
);
  logic [PTR_W-1:0] left_q  [ENTRIES];
  logic [PTR_W-1:0] right_q [ENTRIES];
  logic             has_q   [ENTRIES];
  logic [HOP_W-1:0] hop_q   [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) begin
        left_q[i]  <= NULL_PTR;
        right_q[i] <= NULL_PTR;
        has_q[i]   <= 1'b0;
        hop_q[i]   <= '0;
      end
    end else if (we_i) begin
      left_q[widx_i]  <= wleft_i;
      right_q[widx_i] <= wright_i;
      has_q[widx_i]   <= whas_i;
      hop_q[widx_i]   <= whop_i;
    end
  end

  // asynchronous read: a node visit costs a single cycle
  assign rleft_o  = left_q[ridx_i];
  assign rright_o = right_q[ridx_i];
  assign rhas_o   = has_q[ridx_i];
  assign rhop_o   = hop_q[ridx_i];
endmodule

// File: rtl/trie_step.sv
module trie_step
  import lpm_trie_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned PTR_W  = 7,
  parameter int unsigned HOP_W  = 4,
  parameter int unsigned DEP_W  = 4,
  parameter logic [PTR_W-1:0] NULL_PTR = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DEP_W-1:0]  depth_i,
  input  logic [HOP_W-1:0]  hop_i,
  input  logic [PTR_W-1:0]  node_left_i,
  input  logic [PTR_W-1:0]  node_right_i,
  input  logic              node_has_i,
  input  logic [HOP_W-1:0]  node_hop_i,
  output logic [PTR_W-1:0]  nxt_ptr_o,
  output logic [DEP_W-1:0]  nxt_depth_o,
  output logic [HOP_W-1:0]  nxt_hop_o
);
  branch_e dir;

  always_comb begin
    dir = BR_LEFT;
    for (int b = 0; b < ADDR_W; b++) begin
      if (int'(depth_i) == b) dir = branch_e'(addr_i[ADDR_W-1-b]);
    end
  end

  always_comb begin
    nxt_hop_o = node_has_i ? node_hop_i : hop_i;
    if (int'(depth_i) >= int'(ADDR_W)) begin
      // all address bits used: the walk ends here
      nxt_ptr_o   = NULL_PTR;
      nxt_depth_o = depth_i;
    end else begin
      nxt_ptr_o   = (dir == BR_RIGHT) ? node_right_i : node_left_i;
      nxt_depth_o = depth_i + DEP_W'(1);
    end
  end
endmodule

// File: rtl/trie_stage.sv
module trie_stage #(
  parameter int unsigned STAGE_ID   = 0,
  parameter int unsigned NUM_STAGES = 6,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned IDX_W      = 4,
  parameter int unsigned HOP_W      = 4,
  localparam int unsigned TAG_W = $clog2(NUM_STAGES + 1),
  localparam int unsigned PTR_W = TAG_W + IDX_W,
  localparam int unsigned DEP_W = $clog2(ADDR_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [ADDR_W-1:0] in_addr_i,
  input  logic [PTR_W-1:0]  in_ptr_i,
  input  logic [DEP_W-1:0]  in_depth_i,
  input  logic [HOP_W-1:0]  in_hop_i,
  input  logic              in_wvalid_i,
  input  logic [TAG_W-1:0]  in_wstage_i,
  input  logic [IDX_W-1:0]  in_widx_i,
  input  logic [PTR_W-1:0]  in_wleft_i,
  input  logic [PTR_W-1:0]  in_wright_i,
  input  logic              in_whas_i,
  input  logic [HOP_W-1:0]  in_whop_i,
  output logic              out_valid_o,
  output logic [ADDR_W-1:0] out_addr_o,
  output logic [PTR_W-1:0]  out_ptr_o,
  output logic [DEP_W-1:0]  out_depth_o,
  output logic [HOP_W-1:0]  out_hop_o,
  output logic              out_wvalid_o,
  output logic [TAG_W-1:0]  out_wstage_o,
  output logic [IDX_W-1:0]  out_widx_o,
  output logic [PTR_W-1:0]  out_wleft_o,
  output logic [PTR_W-1:0]  out_wright_o,
  output logic              out_whas_o,
  output logic [HOP_W-1:0]  out_whop_o
);
  localparam logic [PTR_W-1:0] NULL_PTR = {TAG_W'(NUM_STAGES), IDX_W'(0)};

  logic             visit, wr_here;
  logic [PTR_W-1:0] nd_left, nd_right, nx_ptr;
  logic             nd_has;
  logic [HOP_W-1:0] nd_hop, nx_hop;
  logic [DEP_W-1:0] nx_depth;

  assign visit   = in_valid_i && (in_ptr_i[PTR_W-1 -: TAG_W] == TAG_W'(STAGE_ID));
  assign wr_here = in_wvalid_i && (in_wstage_i == TAG_W'(STAGE_ID));

  trie_node_mem #(
    .IDX_W(IDX_W), .PTR_W(PTR_W), .HOP_W(HOP_W), .NULL_PTR(NULL_PTR)
  ) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (wr_here),
    .widx_i   (in_widx_i),
    .wleft_i  (in_wleft_i),
    .wright_i (in_wright_i),
    .whas_i   (in_whas_i),
    .whop_i   (in_whop_i),
    .ridx_i   (in_ptr_i[IDX_W-1:0]),
    .rleft_o  (nd_left),
    .rright_o (nd_right),
    .rhas_o   (nd_has),
    .rhop_o   (nd_hop)
  );

  trie_step #(
    .ADDR_W(ADDR_W), .PTR_W(PTR_W), .HOP_W(HOP_W), .DEP_W(DEP_W), .NULL_PTR(NULL_PTR)
  ) u_step (
    .addr_i       (in_addr_i),
    .depth_i      (in_depth_i),
    .hop_i        (in_hop_i),
    .node_left_i  (nd_left),
    .node_right_i (nd_right),
    .node_has_i   (nd_has),
    .node_hop_i   (nd_hop),
    .nxt_ptr_o    (nx_ptr),
    .nxt_depth_o  (nx_depth),
    .nxt_hop_o    (nx_hop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o  <= 1'b0;
      out_addr_o   <= '0;
      out_ptr_o    <= NULL_PTR;
      out_depth_o  <= '0;
      out_hop_o    <= '0;
      out_wvalid_o <= 1'b0;
      out_wstage_o <= '0;
      out_widx_o   <= '0;
      out_wleft_o  <= NULL_PTR;
      out_wright_o <= NULL_PTR;
      out_whas_o   <= 1'b0;
      out_whop_o   <= '0;
    end else begin
      out_valid_o  <= in_valid_i;
      out_addr_o   <= in_addr_i;
      out_ptr_o    <= visit ? nx_ptr   : in_ptr_i;
      out_depth_o  <= visit ? nx_depth : in_depth_i;
      out_hop_o    <= visit ? nx_hop   : in_hop_i;
      out_wvalid_o <= in_wvalid_i;
      out_wstage_o <= in_wstage_i;
      out_widx_o   <= in_widx_i;
      out_wleft_o  <= in_wleft_i;
      out_wright_o <= in_wright_i;
      out_whas_o   <= in_whas_i;
      out_whop_o   <= in_whop_i;
    end
  end
endmodule

// File: rtl/lpm_trie_pipe.sv
module lpm_trie_pipe
  import lpm_trie_pkg::*;
#(
  parameter int unsigned NUM_STAGES = DEF_STAGES,
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  parameter int unsigned IDX_W      = DEF_IDX_W,
  parameter int unsigned HOP_W      = DEF_HOP_W,
  localparam int unsigned TAG_W = $clog2(NUM_STAGES + 1),
  localparam int unsigned PTR_W = TAG_W + IDX_W,
  localparam int unsigned DEP_W = $clog2(ADDR_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lkp_valid_i,
  input  logic [ADDR_W-1:0] lkp_addr_i,
  input  logic              upd_valid_i,
  input  logic [TAG_W-1:0]  upd_stage_i,
  input  logic [IDX_W-1:0]  upd_index_i,
  input  logic [PTR_W-1:0]  upd_left_i,
  input  logic [PTR_W-1:0]  upd_right_i,
  input  logic              upd_has_hop_i,
  input  logic [HOP_W-1:0]  upd_hop_i,
  output logic              res_valid_o,
  output logic [HOP_W-1:0]  res_hop_o
);
  // slot 0 is the entry point, slot s+1 is the register of stage s
  logic [NUM_STAGES:0]             sl_valid;
  logic [NUM_STAGES:0][ADDR_W-1:0] sl_addr;
  logic [NUM_STAGES:0][PTR_W-1:0]  sl_ptr;
  logic [NUM_STAGES:0][DEP_W-1:0]  sl_depth;
  logic [NUM_STAGES:0][HOP_W-1:0]  sl_hop;
  logic [NUM_STAGES:0]             sl_wv;
  logic [NUM_STAGES:0][TAG_W-1:0]  sl_wst;
  logic [NUM_STAGES:0][IDX_W-1:0]  sl_widx;
  logic [NUM_STAGES:0][PTR_W-1:0]  sl_wl;
  logic [NUM_STAGES:0][PTR_W-1:0]  sl_wr;
  logic [NUM_STAGES:0]             sl_wh;
  logic [NUM_STAGES:0][HOP_W-1:0]  sl_whop;

  assign sl_valid[0] = lkp_valid_i;
  assign sl_addr[0]  = lkp_addr_i;
  assign sl_ptr[0]   = '0;           // root: stage 0, index 0
  assign sl_depth[0] = '0;
  assign sl_hop[0]   = '0;
  assign sl_wv[0]    = upd_valid_i;
  assign sl_wst[0]   = upd_stage_i;
  assign sl_widx[0]  = upd_index_i;
  assign sl_wl[0]    = upd_left_i;
  assign sl_wr[0]    = upd_right_i;
  assign sl_wh[0]    = upd_has_hop_i;
  assign sl_whop[0]  = upd_hop_i;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_stage
    trie_stage #(
      .STAGE_ID(s), .NUM_STAGES(NUM_STAGES), .ADDR_W(ADDR_W),
      .IDX_W(IDX_W), .HOP_W(HOP_W)
    ) u_stage (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .in_valid_i   (sl_valid[s]),
      .in_addr_i    (sl_addr[s]),
      .in_ptr_i     (sl_ptr[s]),
      .in_depth_i   (sl_depth[s]),
      .in_hop_i     (sl_hop[s]),
      .in_wvalid_i  (sl_wv[s]),
      .in_wstage_i  (sl_wst[s]),
      .in_widx_i    (sl_widx[s]),
      .in_wleft_i   (sl_wl[s]),
      .in_wright_i  (sl_wr[s]),
      .in_whas_i    (sl_wh[s]),
      .in_whop_i    (sl_whop[s]),
      .out_valid_o  (sl_valid[s+1]),
      .out_addr_o   (sl_addr[s+1]),
      .out_ptr_o    (sl_ptr[s+1]),
      .out_depth_o  (sl_depth[s+1]),
      .out_hop_o    (sl_hop[s+1]),
      .out_wvalid_o (sl_wv[s+1]),
      .out_wstage_o (sl_wst[s+1]),
      .out_widx_o   (sl_widx[s+1]),
      .out_wleft_o  (sl_wl[s+1]),
      .out_wright_o (sl_wr[s+1]),
      .out_whas_o   (sl_wh[s+1]),
      .out_whop_o   (sl_whop[s+1])
    );
  end

  assign res_valid_o = sl_valid[NUM_STAGES];
  assign res_hop_o   = sl_valid[NUM_STAGES] ? sl_hop[NUM_STAGES] : '0;

  logic unused_tail;
  assign unused_tail = ^{sl_addr[NUM_STAGES], sl_ptr[NUM_STAGES], sl_depth[NUM_STAGES],
                         sl_wv[NUM_STAGES], sl_wst[NUM_STAGES], sl_widx[NUM_STAGES],
                         sl_wl[NUM_STAGES], sl_wr[NUM_STAGES], sl_wh[NUM_STAGES],
                         sl_whop[NUM_STAGES]};
endmodule

// File: rtl/lpm_trie_pipe_chk.sv
module lpm_trie_pipe_chk #(
  parameter int unsigned NUM_STAGES = 6,
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned IDX_W      = 4,
  parameter int unsigned HOP_W      = 4,
  localparam int unsigned TAG_W = $clog2(NUM_STAGES + 1),
  localparam int unsigned PTR_W = TAG_W + IDX_W,
  localparam int unsigned DEP_W = $clog2(ADDR_W + 1)
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            lkp_valid_i,
  input logic                            upd_valid_i,
  input logic [TAG_W-1:0]                upd_stage_i,
  input logic                            res_valid_o,
  input logic [NUM_STAGES:0]             sl_valid,
  input logic [NUM_STAGES:0][ADDR_W-1:0] sl_addr,
  input logic [NUM_STAGES:0][PTR_W-1:0]  sl_ptr,
  input logic [NUM_STAGES:0][DEP_W-1:0]  sl_depth,
  input logic [NUM_STAGES:0][HOP_W-1:0]  sl_hop
);
  logic [NUM_STAGES-1:0] vld_sr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_sr <= '0;
    else         vld_sr <= {vld_sr[NUM_STAGES-2:0], lkp_valid_i};
  end

  AST_FIXED_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o == vld_sr[NUM_STAGES-1]);  // R1

  AST_UPD_STAGE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |-> (int'(upd_stage_i) < int'(NUM_STAGES)));  // R5

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_chk
    AST_SLOT_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sl_valid[s] |=> (sl_valid[s+1] && sl_addr[s+1] == $past(sl_addr[s])));  // R1

    AST_NOP_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sl_valid[s] && sl_ptr[s][PTR_W-1 -: TAG_W] != TAG_W'(s))
      |=> (sl_ptr[s+1] == $past(sl_ptr[s]) && sl_hop[s+1] == $past(sl_hop[s])
           && sl_depth[s+1] == $past(sl_depth[s])));  // R3

    AST_VISIT_DEPTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (sl_valid[s] && sl_ptr[s][PTR_W-1 -: TAG_W] == TAG_W'(s)
       && int'(sl_depth[s]) < int'(ADDR_W))
      |=> (sl_depth[s+1] == DEP_W'($past(sl_depth[s]) + DEP_W'(1))));  // R2

    AST_DEPTH_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      int'(sl_depth[s+1]) <= int'(ADDR_W));  // R2
  end
endmodule

bind lpm_trie_pipe lpm_trie_pipe_chk #(
  .NUM_STAGES(NUM_STAGES), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .HOP_W(HOP_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lkp_valid_i (lkp_valid_i),
  .upd_valid_i (upd_valid_i),
  .upd_stage_i (upd_stage_i),
  .res_valid_o (res_valid_o),
  .sl_valid    (sl_valid),
  .sl_addr     (sl_addr),
  .sl_ptr      (sl_ptr),
  .sl_depth    (sl_depth),
  .sl_hop      (sl_hop)
);

// File: tb/lpm_trie_pipe_tb.sv
`timescale 1ns/1ps
module lpm_trie_pipe_tb;
  localparam int N  = 6;
  localparam int AW = 8;
  localparam int IW = 4;
  localparam int HW = 4;
  localparam int TW = 3;
  localparam int PW = TW + IW;
  localparam int RING = 1024;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          lkp_valid_i = 1'b0;
  logic [AW-1:0] lkp_addr_i = '0;
  logic          upd_valid_i = 1'b0;
  logic [TW-1:0] upd_stage_i = '0;
  logic [IW-1:0] upd_index_i = '0;
  logic [PW-1:0] upd_left_i = '0;
  logic [PW-1:0] upd_right_i = '0;
  logic          upd_has_hop_i = 1'b0;
  logic [HW-1:0] upd_hop_i = '0;
  logic          res_valid_o;
  logic [HW-1:0] res_hop_o;

  always #2.5 clk_i = ~clk_i;

  lpm_trie_pipe u_dut (.*);

  int n_checks = 0, n_fails = 0, cyc = 0;
  bit done = 0;
  string cur_tag = "R6";
  logic          exp_v [RING];
  logic [HW-1:0] exp_h [RING];

  // reference prefix table
  int p_val[32], p_len[32], p_hop[32], p_cnt = 0;
  // bench-built trie
  int t_stage[64], t_idx[64], t_left[64], t_right[64], t_has[64], t_hop[64], t_cnt = 0;
  int st_cnt[N];
  int phase = 0;

  function automatic int lpm(input int a);
    int bl = -1, h = 0;
    for (int k = 0; k < p_cnt; k++)
      if ((p_len[k] == 0 || (a >> (AW - p_len[k])) == p_val[k]) && p_len[k] > bl) begin
        bl = p_len[k]; h = p_hop[k];
      end
    return h;
  endfunction

  function automatic int stage_for(input int d);
    int tbl[4] = '{0, 2, 4, 5};
    return (phase == 0) ? d : tbl[d];
  endfunction

  function automatic logic [PW-1:0] ptr_of(input int id);
    if (id < 0) return {TW'(N), IW'(0)};
    return {TW'(t_stage[id]), IW'(t_idx[id])};
  endfunction

  function automatic int new_node(input int d);
    int id = t_cnt;
    t_stage[id] = stage_for(d);
    t_idx[id] = st_cnt[t_stage[id]];
    st_cnt[t_stage[id]]++;
    t_left[id] = -1; t_right[id] = -1; t_has[id] = 0; t_hop[id] = 0;
    t_cnt++;
    return id;
  endfunction

  task automatic clear_tables();
    t_cnt = 0; p_cnt = 0;
    for (int s = 0; s < N; s++) st_cnt[s] = 0;
    void'(new_node(0));
  endtask

  // trie insertion only; the reference table is updated separately
  task automatic trie_ins(input int val, input int len, input int hop, output int leaf, output int par);
    int cur = 0;
    par = -1;
    for (int d = 0; d < len; d++) begin
      int bt = (val >> (len - 1 - d)) & 1;
      int ch = bt ? t_right[cur] : t_left[cur];
      if (ch < 0) begin
        ch = new_node(d + 1);
        if (bt) t_right[cur] = ch; else t_left[cur] = ch;
      end
      par = cur; cur = ch;
    end
    t_has[cur] = 1; t_hop[cur] = hop; leaf = cur;
  endtask

  task automatic add_pfx(input int val, input int len, input int hop);
    p_val[p_cnt] = val; p_len[p_cnt] = len; p_hop[p_cnt] = hop; p_cnt++;
  endtask

  task automatic route(input int val, input int len, input int hop);
    int lf, pr;
    trie_ins(val, len, hop, lf, pr);
    add_pfx(val, len, hop);
  endtask

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // one cycle: score the output due now, then drive this cycle's inputs
  task automatic drive(input logic v, input int a, input int wid);
    @(negedge clk_i);
    if (cyc >= N) begin
      int k = (cyc - N) % RING;
      check("R1", "res_valid_o", int'(res_valid_o), int'(exp_v[k]));
      if (exp_v[k]) check(cur_tag, "res_hop_o", int'(res_hop_o), int'(exp_h[k]));
      else          check("R7", "res_hop_o idle", int'(res_hop_o), 0);
    end else begin
      check("R6", "res_valid_o after reset", int'(res_valid_o), 0);
    end
    lkp_valid_i = v;
    lkp_addr_i  = AW'(a);
    upd_valid_i = (wid >= 0);
    if (wid >= 0) begin
      upd_stage_i   = TW'(t_stage[wid]);
      upd_index_i   = IW'(t_idx[wid]);
      upd_left_i    = ptr_of(t_left[wid]);
      upd_right_i   = ptr_of(t_right[wid]);
      upd_has_hop_i = t_has[wid][0];
      upd_hop_i     = HW'(t_hop[wid]);
    end
    exp_v[cyc % RING] = v;
    exp_h[cyc % RING] = v ? HW'(lpm(a)) : '0;
    cyc++;
  endtask

  task automatic write_all();
    for (int i = 0; i < t_cnt; i++) drive(1'b0, 0, i);
    drive(1'b0, 0, -1);
  endtask

  task automatic sweep(input int lo, input int hi, input int gap);
    for (int a = lo; a <= hi; a++) begin
      drive(1'b1, a, -1);
      if (gap > 0 && (a % gap) == 0) drive(1'b0, 0, -1);
    end
  endtask

  initial begin
    int lf, pr, id111;
    repeat (3) @(negedge clk_i);
    check("R6", "res_valid_o in reset", int'(res_valid_o), 0);
    rst_ni = 1'b1;

    // R6: empty memories answer 0 everywhere
    cur_tag = "R6";
    sweep(0, 255, 0);

    // phase 0: node of depth d in stage d
    phase = 0;
    clear_tables();
    route(0, 0, 1);       route(1, 1, 2);     route(3'b010, 3, 3);
    route(5'b01011, 5, 4); route(4'b1100, 4, 5); route(2'b00, 2, 6);
    route(5'b11111, 5, 7); route(3'b101, 3, 8);
    write_all();
    cur_tag = "R2";
    sweep(0, 255, 0);     // back-to-back, full address space
    cur_tag = "R1";
    sweep(0, 255, 3);     // idle holes between lookups

    // phase 1: nop stages between levels, no default route
    phase = 1;
    clear_tables();
    route(0, 1, 9);       route(2'b10, 2, 10);
    route(3'b111, 3, 11); route(3'b011, 3, 12);
    write_all();
    cur_tag = "R3";
    sweep(0, 255, 0);
    cur_tag = "R4";       // left subtree of '0' has null children: walk ends
    sweep(8'h00, 8'h3F, 5);

    // R5: updates ride with a live lookup stream
    cur_tag = "R5";
    trie_ins(3'b111, 3, 11, id111, pr);
    for (int c = 0; c < 160; c++) begin
      int a = (c % 2) ? 8'hC0 : 8'hE0;
      if (c == 50) begin
        t_hop[id111] = 13;
        drive(1'b1, a, id111);
        for (int k = 0; k < p_cnt; k++) if (p_len[k] == 3 && p_val[k] == 7) p_hop[k] = 13;
      end else if (c == 100) begin
        trie_ins(3'b110, 3, 14, lf, pr);
        drive(1'b1, a, lf);
      end else if (c == 101) begin
        drive(1'b1, a, pr);
        add_pfx(3'b110, 3, 14);
      end else begin
        drive(1'b1, a, -1);
      end
    end

    cur_tag = "R1";
    for (int i = 0; i < N + 2; i++) drive(1'b0, 0, -1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule